// File: doc/BRIEF.md
# CAN Acceptance Filter Engine

This block routes a received CAN frame to its destination queue. After the receiver has captured the arbitration field and the first three payload bytes, a one-cycle start pulse launches a scan. The scan walks a bank of 32 programmable filter/mask pairs, one filter per clock, starting with filter 0, which has the highest priority. Each filter tests the identifier, the IDE flag and the three payload bytes under its mask. It names a destination FIFO through a pointer.

The per-FIFO status inputs describe each FIFO's role (receive or transmit), whether it answers remote frames, and whether it is full or empty. With these, the engine picks one outcome. It can store the frame in a receive FIFO. It can request a transmission from a transmit FIFO in answer to a remote frame. It can flag an overflow, or it can discard the frame. The result appears as one-cycle pulses in the same cycle as the done pulse. If the frame's error-free indication is low at that point, the pulses are suppressed. The bit engine, frame assembly and FIFO storage sit outside this block.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every filter is disabled and done, storeStb, rxInt, txReq, overflow and discard are all low.
- R2: The compare vector is {IDE at bit 53, identifier at bits 52:24, payload byte 0 at 23:16, byte 1 at 15:8, byte 2 at 7:0}. An enabled filter matches when every bit set in its mask equals the same bit of its value. A disabled filter never matches.
- R3: The lowest-numbered matching filter whose destination is a non-full receive FIFO wins. It produces storeStb with storeIdx equal to its pointer and a one-hot rxInt bit for that FIFO, and the scan stops there.
- R4: A match whose receive FIFO is full does not stop the scan. Scanning continues at the next filter.
- R5: If every matching filter names a full receive FIFO, only the overflow bit of the FIFO named by the lowest-numbered matching filter is set, with no store.
- R6: A remote frame (frmRtr=1) that matches a filter naming a transmit FIFO (fifoIsTx=1) with remote reply enabled (fifoRtrEn=1) and not empty sets that FIFO's txReq bit and stops the scan.
- R7: In the R6 case with that transmit FIFO empty, its overflow bit is set instead of txReq.
- R8: A match on a transmit FIFO in any other case (remote reply disabled, or a data frame) asserts discard and stops the scan.
- R9: When no enabled filter matches, discard is asserted after all 32 filters are scanned.
- R10: Config writes use cfgField 0 for enable (cfgData bit 0), 1 for value, 2 for mask and 3 for pointer (low bits). Value, mask and pointer writes to a filter whose enable is set are ignored.
- R11: done pulses exactly once per scan, k+1 cycles after the start edge, where k is the filter that ended the scan, or 32 cycles after it when no filter ends it. A start pulse during a scan is ignored.
- R12: If frmOk is low in the deciding cycle, no storeStb, rxInt, txReq, overflow or discard is produced; done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Config write strobe |
| cfgIdx | input | 5 | Filter selected by the write |
| cfgField | input | 2 | Field written: 0 enable, 1 value, 2 mask, 3 pointer |
| cfgData | input | 54 | Write data |
| start | input | 1 | Begin a scan with the frame currently on the frame inputs |
| frmIde | input | 1 | Extended-identifier flag |
| frmId | input | 29 | Received identifier |
| frmData | input | 24 | First three payload bytes, byte 0 in the top byte |
| frmRtr | input | 1 | Remote-frame flag |
| frmOk | input | 1 | Frame received without error |
| fifoIsTx | input | 8 | Per-FIFO transmit role |
| fifoRtrEn | input | 8 | Per-FIFO remote reply enable |
| fifoFull | input | 8 | Per-FIFO full |
| fifoEmpty | input | 8 | Per-FIFO empty |
| done | output | 1 | Scan finished pulse |
| storeStb | output | 1 | Store the frame |
| storeIdx | output | 3 | Destination FIFO for storeStb |
| rxInt | output | 8 | One-hot receive-interrupt pulse |
| txReq | output | 8 | One-hot transmit-request pulse |
| overflow | output | 8 | One-hot overflow pulse |
| discard | output | 1 | Frame dropped |

## Verification
A wrong scan index or a lost first-match record shows at the ports only when the scan ends. The symptoms are a done pulse in the wrong cycle, a store on a lower-priority FIFO, or an overflow on the wrong FIFO. All of these appear within 33 cycles of the start pulse. A config write that slips past the enable lock stays hidden until a later frame matches or fails to match that filter. For that reason the bench sweeps many frames over each configuration and compares every outcome, including the done latency, against an arithmetic model.

// File: rtl/canaf_pkg.sv
package canaf_pkg;
  typedef enum logic [1:0] {
    CF_ENABLE  = 2'd0,
    CF_VALUE   = 2'd1,
    CF_MASK    = 2'd2,
    CF_POINTER = 2'd3
  } cfgField_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic recordFirst;
  } afCtl_t;

  typedef enum logic [2:0] {
    OC_NONE,
    OC_STORE,
    OC_TXREQ,
    OC_OVF_TX,
    OC_OVF_RX,
    OC_DISCARD
  } outcome_e;
endpackage

// File: rtl/canaf_datapath.sv
module canaf_datapath
  import canaf_pkg::*;
#(
  parameter int FILT_N = 32,
  parameter int FIFO_N = 8,
  parameter int ID_W   = 29,
  parameter int DATA_W = 24,
  localparam int IDX_W = $clog2(FILT_N),
  localparam int PTR_W = $clog2(FIFO_N),
  localparam int CMP_W = 1 + ID_W + DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [1:0]       cfgField,
  input  logic [CMP_W-1:0] cfgData,
  input  logic             frmIde,
  input  logic [ID_W-1:0]  frmId,
  input  logic [DATA_W-1:0] frmData,
  input  logic             frmRtr,
  input  afCtl_t           ctl,
  output logic             curHit,
  output logic [PTR_W-1:0] curPtr,
  output logic             atLast,
  output logic             firstValid,
  output logic [PTR_W-1:0] firstPtr,
  output logic             frmRtrQ
);
  logic [CMP_W-1:0] filtVal  [FILT_N];
  logic [CMP_W-1:0] filtMask [FILT_N];
  logic [PTR_W-1:0] filtPtr  [FILT_N];
  logic [FILT_N-1:0] filtEn;
  logic [FILT_N-1:0] hitVec;
  logic [CMP_W-1:0] frmVecQ;
  logic [IDX_W-1:0] scanIdx;

  for (genvar g = 0; g < FILT_N; g++) begin : gFilt
    logic selW;
    assign selW = cfgWe && (cfgIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        filtEn[g]   <= 1'b0;
        filtVal[g]  <= '0;
        filtMask[g] <= '0;
        filtPtr[g]  <= '0;
      end else if (selW) begin
        case (cfgField)
          CF_ENABLE:  filtEn[g] <= cfgData[0];
          CF_VALUE:   if (!filtEn[g]) filtVal[g]  <= cfgData;
          CF_MASK:    if (!filtEn[g]) filtMask[g] <= cfgData;
          default:    if (!filtEn[g]) filtPtr[g]  <= cfgData[PTR_W-1:0];
        endcase
      end
    end

    assign hitVec[g] = filtEn[g] && (((frmVecQ ^ filtVal[g]) & filtMask[g]) == '0);

    AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
      (selW && filtEn[g] && (cfgField != CF_ENABLE)) |=>
        ($stable(filtVal[g]) && $stable(filtMask[g]) && $stable(filtPtr[g]))); // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmVecQ    <= '0;
      frmRtrQ    <= 1'b0;
      scanIdx    <= '0;
      firstValid <= 1'b0;
      firstPtr   <= '0;
    end else begin
      if (ctl.load) begin
        frmVecQ    <= {frmIde, frmId, frmData};
        frmRtrQ    <= frmRtr;
        scanIdx    <= '0;
        firstValid <= 1'b0;
      end else begin
        if (ctl.advance) scanIdx <= scanIdx + 1'b1;
        if (ctl.recordFirst && !firstValid) begin
          firstValid <= 1'b1;
          firstPtr   <= curPtr;
        end
      end
    end
  end

  assign curHit = hitVec[scanIdx];
  assign curPtr = filtPtr[scanIdx];
  assign atLast = (scanIdx == IDX_W'(FILT_N - 1));

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.load) |=> (scanIdx == $past(scanIdx) + 1'b1)); // R11
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (firstValid && !ctl.load) |=> (firstValid && $stable(firstPtr))); // R5
endmodule

// File: rtl/canaf_control.sv
module canaf_control
  import canaf_pkg::*;
#(
  parameter int FIFO_N = 8,
  localparam int PTR_W = $clog2(FIFO_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              frmOk,
  input  logic              curHit,
  input  logic [PTR_W-1:0]  curPtr,
  input  logic              atLast,
  input  logic              firstValid,
  input  logic [PTR_W-1:0]  firstPtr,
  input  logic              frmRtrQ,
  input  logic [FIFO_N-1:0] fifoIsTx,
  input  logic [FIFO_N-1:0] fifoRtrEn,
  input  logic [FIFO_N-1:0] fifoFull,
  input  logic [FIFO_N-1:0] fifoEmpty,
  output afCtl_t            ctl,
  output logic              done,
  output logic              storeStb,
  output logic [PTR_W-1:0]  storeIdx,
  output logic [FIFO_N-1:0] rxInt,
  output logic [FIFO_N-1:0] txReq,
  output logic [FIFO_N-1:0] overflow,
  output logic              discard
);
  localparam logic [FIFO_N-1:0] ONE = FIFO_N'(1);

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
  state_e   state, stateNext;
  outcome_e outcome;
  logic     finish;
  logic [PTR_W-1:0] resPtr;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    outcome   = OC_NONE;
    finish    = 1'b0;
    resPtr    = curPtr;
    if (state == ST_IDLE) begin
      if (start) begin
        ctl.load  = 1'b1;
        stateNext = ST_SCAN;
      end
    end else begin
      if (curHit) begin
        if (fifoIsTx[curPtr]) begin
          finish = 1'b1;
          if (frmRtrQ && fifoRtrEn[curPtr])
            outcome = fifoEmpty[curPtr] ? OC_OVF_TX : OC_TXREQ;
          else
            outcome = OC_DISCARD;
        end else if (!fifoFull[curPtr]) begin
          finish  = 1'b1;
          outcome = OC_STORE;
        end else begin
          ctl.recordFirst = 1'b1;
        end
      end
      if (!finish) begin
        if (atLast) begin
          finish = 1'b1;
          if (firstValid) begin
            outcome = OC_OVF_RX;
            resPtr  = firstPtr;
          end else if (ctl.recordFirst) begin
            outcome = OC_OVF_RX;
          end else begin
            outcome = OC_DISCARD;
          end
        end else begin
          ctl.advance = 1'b1;
        end
      end
      if (finish) stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      storeStb <= 1'b0;
      storeIdx <= '0;
      rxInt    <= '0;
      txReq    <= '0;
      overflow <= '0;
      discard  <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= finish;
      storeStb <= 1'b0;
      rxInt    <= '0;
      txReq    <= '0;
      overflow <= '0;
      discard  <= 1'b0;
      if (finish && frmOk) begin
        case (outcome)
          OC_STORE: begin
            storeStb <= 1'b1;
            storeIdx <= resPtr;
            rxInt    <= ONE << resPtr;
          end
          OC_TXREQ:   txReq    <= ONE << resPtr;
          OC_OVF_TX,
          OC_OVF_RX:  overflow <= ONE << resPtr;
          OC_DISCARD: discard  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_OVF_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(overflow)); // R5
  AST_TXREQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txReq)); // R6
  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb || discard || (|overflow) || (|txReq)) |-> done); // R3
  AST_OK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb || discard || (|overflow) || (|txReq)) |-> $past(frmOk)); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({storeStb, discard, |overflow, |txReq}) <= 1)); // R8
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import canaf_pkg::*;
#(
  parameter int FILT_N = 32,
  parameter int FIFO_N = 8,
  parameter int ID_W   = 29,
  parameter int DATA_W = 24,
  localparam int IDX_W = $clog2(FILT_N),
  localparam int PTR_W = $clog2(FIFO_N),
  localparam int CMP_W = 1 + ID_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [CMP_W-1:0]  cfgData,
  input  logic              start,
  input  logic              frmIde,
  input  logic [ID_W-1:0]   frmId,
  input  logic [DATA_W-1:0] frmData,
  input  logic              frmRtr,
  input  logic              frmOk,
  input  logic [FIFO_N-1:0] fifoIsTx,
  input  logic [FIFO_N-1:0] fifoRtrEn,
  input  logic [FIFO_N-1:0] fifoFull,
  input  logic [FIFO_N-1:0] fifoEmpty,
  output logic              done,
  output logic              storeStb,
  output logic [PTR_W-1:0]  storeIdx,
  output logic [FIFO_N-1:0] rxInt,
  output logic [FIFO_N-1:0] txReq,
  output logic [FIFO_N-1:0] overflow,
  output logic              discard
);
  afCtl_t           ctl;
  logic             curHit, atLast, firstValid, frmRtrQ;
  logic [PTR_W-1:0] curPtr, firstPtr;

  canaf_datapath #(.FILT_N(FILT_N), .FIFO_N(FIFO_N), .ID_W(ID_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgField(cfgField),
    .cfgData(cfgData), .frmIde(frmIde), .frmId(frmId), .frmData(frmData),
    .frmRtr(frmRtr), .ctl(ctl), .curHit(curHit), .curPtr(curPtr), .atLast(atLast),
    .firstValid(firstValid), .firstPtr(firstPtr), .frmRtrQ(frmRtrQ)
  );

  canaf_control #(.FIFO_N(FIFO_N)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .frmOk(frmOk), .curHit(curHit),
    .curPtr(curPtr), .atLast(atLast), .firstValid(firstValid), .firstPtr(firstPtr),
    .frmRtrQ(frmRtrQ), .fifoIsTx(fifoIsTx), .fifoRtrEn(fifoRtrEn),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .ctl(ctl), .done(done),
    .storeStb(storeStb), .storeIdx(storeIdx), .rxInt(rxInt), .txReq(txReq),
    .overflow(overflow), .discard(discard)
  );
endmodule

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        cfgWe = 0;
  logic [4:0]  cfgIdx = 0;
  logic [1:0]  cfgField = 0;
  logic [53:0] cfgData = 0;
  logic        start = 0, frmIde = 0, frmRtr = 0, frmOk = 1;
  logic [28:0] frmId = 0;
  logic [23:0] frmData = 0;
  logic [7:0]  fifoIsTx = 0, fifoRtrEn = 0, fifoFull = 0, fifoEmpty = 0;
  logic        done, storeStb, discard;
  logic [2:0]  storeIdx;
  logic [7:0]  rxInt, txReq, overflow;

  can_accept_filter u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgField(cfgField),
    .cfgData(cfgData), .start(start), .frmIde(frmIde), .frmId(frmId),
    .frmData(frmData), .frmRtr(frmRtr), .frmOk(frmOk), .fifoIsTx(fifoIsTx),
    .fifoRtrEn(fifoRtrEn), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .done(done), .storeStb(storeStb), .storeIdx(storeIdx), .rxInt(rxInt),
    .txReq(txReq), .overflow(overflow), .discard(discard)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  logic [53:0] mVal [32];
  logic [53:0] mMask[32];
  logic [2:0]  mPtr [32];
  logic        mEn  [32];

  logic       eStore, eDisc;
  logic [2:0] eIdx;
  logic [7:0] eTx, eOvf;
  int         eLat;
  logic [31:0] rng = 32'h1234_5678;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int idx, input logic [1:0] fld, input logic [53:0] d);
    @(negedge clk);
    cfgWe = 1; cfgIdx = idx[4:0]; cfgField = fld; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
    if (fld == 2'd0) mEn[idx] = d[0];
    else if (!mEn[idx]) begin
      if (fld == 2'd1) mVal[idx] = d;
      else if (fld == 2'd2) mMask[idx] = d;
      else mPtr[idx] = d[2:0];
    end
  endtask

  task automatic setFilter(input int idx, input logic [53:0] v, input logic [53:0] m, input int p);
    cfgWrite(idx, 2'd0, 54'd0);
    cfgWrite(idx, 2'd1, v);
    cfgWrite(idx, 2'd2, m);
    cfgWrite(idx, 2'd3, 54'(p));
    cfgWrite(idx, 2'd0, 54'd1);
  endtask

  task automatic clearAll();
    for (int i = 0; i < 32; i++) cfgWrite(i, 2'd0, 54'd0);
  endtask

  function automatic void model(input logic [53:0] vec, input logic rtr, input logic ok);
    logic haveFirst = 0;
    logic [2:0] first = 0;
    logic [2:0] p;
    eStore = 0; eDisc = 0; eIdx = 0; eTx = 0; eOvf = 0; eLat = 32;
    for (int i = 0; i < 32; i++) begin
      if (mEn[i] && (((vec ^ mVal[i]) & mMask[i]) == 54'd0)) begin
        p = mPtr[i];
        if (fifoIsTx[p]) begin
          if (rtr && fifoRtrEn[p]) begin
            if (fifoEmpty[p]) eOvf[p] = 1'b1; else eTx[p] = 1'b1;
          end else eDisc = 1;
          eLat = i + 1;
          break;
        end else if (!fifoFull[p]) begin
          eStore = 1; eIdx = p; eLat = i + 1;
          break;
        end else if (!haveFirst) begin
          haveFirst = 1; first = p;
        end
      end
    end
    if (eLat == 32 && !eStore && !eDisc && eTx == 0 && eOvf == 0) begin
      if (haveFirst) eOvf[first] = 1'b1; else eDisc = 1;
    end
    if (!ok) begin
      eStore = 0; eDisc = 0; eIdx = 0; eTx = 0; eOvf = 0;
    end
  endfunction

  task automatic runFrame(input string tag, input logic ide, input logic [28:0] id,
                          input logic [23:0] dat, input logic rtr, input logic ok,
                          input int glitchAt);
    int lat = 0;
    model({ide, id, dat}, rtr, ok);
    @(negedge clk);
    frmIde = ide; frmId = id; frmData = dat; frmRtr = rtr; frmOk = ok; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    do begin
      if (lat == glitchAt) begin
        start = 1; frmId = ~id; frmData = ~dat; frmIde = ~ide;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 0;
    end while (!done && lat < 40);
    chk({tag, " done latency"}, 64'(lat), 64'(eLat));
    chk({tag, " storeStb"}, 64'(storeStb), 64'(eStore));
    if (eStore) chk({tag, " storeIdx"}, 64'(storeIdx), 64'(eIdx));
    chk({tag, " rxInt"}, 64'(rxInt), eStore ? 64'(8'd1 << eIdx) : 64'd0);
    chk({tag, " txReq"}, 64'(txReq), 64'(eTx));
    chk({tag, " overflow"}, 64'(overflow), 64'(eOvf));
    chk({tag, " discard"}, 64'(discard), 64'(eDisc));
    @(negedge clk);
    chk({tag, " done single pulse"}, 64'(done), 64'd0);
  endtask

  localparam logic [53:0] ID_MASK = {1'b1, {29{1'b1}}, 24'd0};

  function automatic logic [53:0] idVec(input logic [28:0] id);
    return {1'b0, id, 24'd0};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      mVal[i] = 0; mMask[i] = 0; mPtr[i] = 0; mEn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 64'(done), 0);
    chk("R1 outputs", 64'({storeStb, discard, rxInt, txReq, overflow}), 0);

    // R9 nothing enabled
    runFrame("R9 no filter", 0, 29'h123, 24'h0, 0, 1, -1);

    // R3 priority: filter 3 and 5 both match, 3 wins
    setFilter(5, idVec(29'h0ABC), ID_MASK, 2);
    setFilter(3, idVec(29'h0ABC), ID_MASK, 4);
    runFrame("R3 priority", 0, 29'h0ABC, 24'hFFEEDD, 0, 1, -1);
    // R4 fifo 4 full: fall through to filter 5
    fifoFull = 8'b0001_0000;
    runFrame("R4 fall through", 0, 29'h0ABC, 24'h0, 0, 1, -1);
    // R5 all matches full: overflow on fifo 4
    fifoFull = 8'b0001_0100;
    runFrame("R5 overflow first", 0, 29'h0ABC, 24'h0, 0, 1, -1);
    fifoFull = 0;
    // R2 IDE bit matters, and data byte 0 filter
    runFrame("R2 ide differs", 1, 29'h0ABC, 24'h0, 0, 1, -1);
    setFilter(10, {30'd0, 8'h5A, 16'd0}, {30'd0, 8'hFF, 16'd0}, 6);
    runFrame("R2 byte0 match", 0, 29'h1, 24'h5A0102, 0, 1, -1);
    runFrame("R2 byte0 miss", 0, 29'h1, 24'h5B0102, 0, 1, -1);

    // R6 R7 R8 transmit FIFOs
    clearAll();
    fifoIsTx = 8'b1000_0000; fifoRtrEn = 8'b1000_0000; fifoEmpty = 0;
    setFilter(0, idVec(29'h77), ID_MASK, 7);
    runFrame("R6 remote reply", 0, 29'h77, 24'h0, 1, 1, -1);
    fifoEmpty = 8'b1000_0000;
    runFrame("R7 tx empty", 0, 29'h77, 24'h0, 1, 1, -1);
    runFrame("R8 data frame to tx", 0, 29'h77, 24'h0, 0, 1, -1);
    fifoRtrEn = 0;
    runFrame("R8 reply disabled", 0, 29'h77, 24'h0, 1, 1, -1);
    fifoIsTx = 0; fifoRtrEn = 0; fifoEmpty = 0;

    // R10 locked writes while enabled
    clearAll();
    setFilter(9, idVec(29'h200), ID_MASK, 1);
    cfgWrite(9, 2'd1, idVec(29'h300));
    cfgWrite(9, 2'd3, 54'd5);
    runFrame("R10 old value kept", 0, 29'h200, 24'h0, 0, 1, -1);
    runFrame("R10 new value ignored", 0, 29'h300, 24'h0, 0, 1, -1);

    // R11 restart ignored during scan
    runFrame("R11 restart ignored", 0, 29'h200, 24'h0, 0, 1, 3);
    runFrame("R11 restart no-match", 0, 29'h555, 24'h0, 0, 1, 5);

    // R12 error frame
    runFrame("R12 frame error", 0, 29'h200, 24'h0, 0, 0, -1);

    // R2 sweep over pseudo-random configurations
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 32; i++) begin
        logic [31:0] a = nextRand();
        logic [31:0] b = nextRand();
        setFilter(i, {a[21:0], b}, {51'd0, a[2:0]} << (b[5:0] % 6'd51) | 54'(b[31]) << 53, int'(a[31:29]));
      end
      for (int f = 0; f < 20; f++) begin
        logic [31:0] a = nextRand();
        logic [31:0] b = nextRand();
        logic [31:0] s = nextRand();
        fifoIsTx = s[7:0] & s[15:8]; fifoRtrEn = s[23:16];
        fifoFull = s[31:24]; fifoEmpty = a[7:0];
        runFrame("R2 sweep", b[0], {b[28:8], a[15:8]}, {a[31:16], b[31:24]}, b[29], b[30] | b[1], -1);
      end
    end

    summary();
  end
endmodule